// File: doc/BRIEF.md
# Clock-Forwarded Serial Link Transceiver

This block moves one word at a time between two chips over three wires: a serial clock, a data output and a data input. A single shift register sends its contents from the most significant end while received bits enter at the least significant end, so each word transfer is both a send and a receive. Software-visible framing is not part of the block. The host writes a word through the parallel port, waits for the one-cycle done pulse, and reads the received word.

In master mode the block drives the serial clock. The clock either toggles on every system clock, which gives half the system rate, or toggles on each pulse of an external tick input, so a counter elsewhere can set the bit rate. In slave mode the block follows a clock from the far side. That clock and the incoming data are brought into the system domain through a synchronizer, and edges are detected there, so the incoming clock must stay at or below half the system clock. The link behaves as SPI mode 0: the clock idles low, data changes on the falling edge and is sampled on the rising edge. A word is 8, 16 or 32 bits long.

Top module: `sync_link_xcvr`

## Requirements
- R1: After reset, busy, done, sclk_o, sdo and rd_data are all 0.
- R2: len_sel selects the word length: 00 gives 8 bits, 01 gives 16, 10 and 11 give 32. In master mode with clk_src_ext=0, busy rises on the clock edge that accepts wr_en. sclk_o then toggles on every following system clock. done is high exactly 2*N cycles after the accepting edge, where N is the word length.
- R3: Data goes out MSB first. After a word is accepted, sdo shows bit N-1 of wr_data. After each falling edge of the serial clock, sdo shows the next lower bit, and sdo changes at no other time during a master transfer.
- R4: The received word is sampled on rising edges of the serial clock. When done rises it is readable on rd_data, right-aligned and zero-extended, with the first received bit at bit N-1.
- R5: In master mode with clk_src_ext=1, sclk_o toggles only on clock edges where ext_tick was high. It keeps its value on all other edges.
- R6: In slave mode (mode_master=0), sclk_o stays 0. The block shifts on synchronized edges of sclk_i, sends the loaded word MSB first on sdo and receives from sdi as in R4.
- R7: done is high for exactly one system clock per word, and busy falls on the same edge on which done rises.
- R8: A write (wr_en) while busy is high is ignored. The word being sent and the word received are unchanged.
- R9: sclk_o is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = drive the serial clock, 0 = follow sclk_i |
| clk_src_ext | input | 1 | Master clock source: 0 = half system rate, 1 = ext_tick |
| ext_tick | input | 1 | Half-period tick for the external clock source |
| len_sel | input | 2 | Word length code (see R2) |
| wr_en | input | 1 | Load wr_data (master: also starts the transfer) |
| wr_data | input | 32 | Parallel word to send, right-aligned |
| rd_data | output | 32 | Received word, right-aligned, zero-extended |
| done | output | 1 | One-cycle pulse at the end of a word |
| busy | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Some rules are checked on every cycle: done is a single-cycle pulse that coincides with busy falling, the clock idles low outside a transfer and stays low in slave mode, sdo moves only with a serial-clock fall, and sclk_o holds still in tick mode when no tick was given. Other behaviour is only shown by the bench scenarios: the exact cycle count per word length, the bit order and alignment of the sent and received words, the ignored mid-transfer write, and correct capture through the slave synchronizer. For these the bench runs a behavioural peer against the design at each word length and in each clock source.

// File: rtl/link_pkg.sv
package link_pkg;
   localparam int unsigned LINK_WORD_MAX = 32;

   typedef enum logic [1:0] {
      WLEN_8   = 2'b00,
      WLEN_16  = 2'b01,
      WLEN_32  = 2'b10,
      WLEN_32B = 2'b11
   } wlen_e;

   function automatic logic [5:0] wlen_bits(input logic [1:0] code);
      case (wlen_e'(code))
         WLEN_8:  return 6'd8;
         WLEN_16: return 6'd16;
         default: return 6'd32;
      endcase
   endfunction
endpackage

// File: rtl/link_clkgen.sv
module link_clkgen #(
   parameter bit EXT_TICK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic use_ext,
   input  logic ext_tick,
   output logic sclk,
   output logic rise_ev,
   output logic fall_ev
);
   logic tick;

   generate
      if (EXT_TICK_EN) begin : g_ext
         assign tick = use_ext ? ext_tick : 1'b1;
      end else begin : g_half
         logic unused_ext;
         assign unused_ext = use_ext ^ ext_tick;
         assign tick       = 1'b1;
      end
   endgenerate

   assign rise_ev = run & tick & ~sclk;
   assign fall_ev = run & tick &  sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sclk <= 1'b0;
      else if (!run)   sclk <= 1'b0;
      else if (tick)   sclk <= ~sclk;
   end
endmodule

// File: rtl/link_edge_sync.sv
module link_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_in,
   input  logic data_in,
   output logic rise,
   output logic fall,
   output logic data_s
);
   logic [STAGES-1:0] c_q, c_d, d_q, d_d;
   logic              c_prev;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            assign c_d[g] = sclk_in;
            assign d_d[g] = data_in;
         end else begin : g_next
            assign c_d[g] = c_q[g-1];
            assign d_d[g] = d_q[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q    <= '0;
         d_q    <= '0;
         c_prev <= 1'b0;
      end else begin
         c_q    <= c_d;
         d_q    <= d_d;
         c_prev <= c_q[STAGES-1];
      end
   end

   assign rise   =  c_q[STAGES-1] & ~c_prev;
   assign fall   = ~c_q[STAGES-1] &  c_prev;
   assign data_s =  d_q[STAGES-1];
endmodule

// File: rtl/link_shifter.sv
module link_shifter #(
   parameter int unsigned MAXW = 32,
   localparam int unsigned LW  = $clog2(MAXW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            master,
   input  logic            load,
   input  logic [MAXW-1:0] load_data,
   input  logic [LW-1:0]   len_live,
   input  logic            cap_ev,
   input  logic            shift_ev,
   input  logic            sdi_bit,
   output logic            sdo,
   output logic [MAXW-1:0] rd_data,
   output logic            done,
   output logic            busy
);
   logic [MAXW-1:0] shreg, mask;
   logic [LW-1:0]   cnt, len_q;
   logic            rx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         cnt    <= '0;
         len_q  <= LW'(MAXW);
         rx_bit <= 1'b0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) len_q <= len_live;
         if (load && !busy) begin
            shreg <= load_data << (LW'(MAXW) - len_live);
            cnt   <= '0;
            if (master) busy <= 1'b1;
         end
         if (cap_ev && (busy || !master)) begin
            rx_bit <= sdi_bit;
            if (!master) busy <= 1'b1;
         end
         if (shift_ev && busy) begin
            shreg <= {shreg[MAXW-2:0], rx_bit};
            if (cnt == len_q - 1'b1) begin
               cnt  <= '0;
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < int'(MAXW); i++) mask[i] = (i < int'(len_q));
   end

   assign rd_data = shreg & mask;
   assign sdo     = shreg[MAXW-1];
endmodule

// File: rtl/sync_link_xcvr.sv
module sync_link_xcvr
   import link_pkg::*;
#(
   parameter int unsigned MAXW        = LINK_WORD_MAX,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_TICK_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_master,
   input  logic            clk_src_ext,
   input  logic            ext_tick,
   input  logic [1:0]      len_sel,
   input  logic            wr_en,
   input  logic [MAXW-1:0] wr_data,
   output logic [MAXW-1:0] rd_data,
   output logic            done,
   output logic            busy,
   output logic            sclk_o,
   input  logic            sclk_i,
   output logic            sdo,
   input  logic            sdi
);
   localparam int unsigned LW = $clog2(MAXW + 1);

   generate
      if (MAXW != 32) begin : g_bad_width
         $error("sync_link_xcvr: MAXW must be 32 to hold the longest word");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sync_link_xcvr: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          gen_sclk, gen_rise, gen_fall;
   logic          syn_rise, syn_fall, syn_data;
   logic          cap_ev, shift_ev, sample_bit;
   logic [LW-1:0] len_live;

   assign len_live = LW'(wlen_bits(len_sel));

   link_clkgen #(.EXT_TICK_EN(EXT_TICK_EN)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy & mode_master),
      .use_ext  (clk_src_ext),
      .ext_tick (ext_tick),
      .sclk     (gen_sclk),
      .rise_ev  (gen_rise),
      .fall_ev  (gen_fall)
   );

   link_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_in (sclk_i),
      .data_in (sdi),
      .rise    (syn_rise),
      .fall    (syn_fall),
      .data_s  (syn_data)
   );

   assign cap_ev     = mode_master ? gen_rise : syn_rise;
   assign shift_ev   = mode_master ? gen_fall : syn_fall;
   assign sample_bit = mode_master ? sdi      : syn_data;

   link_shifter #(.MAXW(MAXW)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .master    (mode_master),
      .load      (wr_en),
      .load_data (wr_data),
      .len_live  (len_live),
      .cap_ev    (cap_ev),
      .shift_ev  (shift_ev),
      .sdi_bit   (sample_bit),
      .sdo       (sdo),
      .rd_data   (rd_data),
      .done      (done),
      .busy      (busy)
   );

   assign sclk_o = mode_master & gen_sclk;
endmodule

// File: rtl/link_xcvr_chk.sv
module link_xcvr_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_master,
   input logic clk_src_ext,
   input logic ext_tick,
   input logic done,
   input logic busy,
   input logic sclk_o,
   input logic sdo
);
   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r7_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r9_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk_o);

   a_r6_slave_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_master |-> !sclk_o);

   a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_master && clk_src_ext && busy && !ext_tick) |=> $stable(sclk_o));

   a_r3_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_master && $past(mode_master) && $past(busy) && !$fell(sclk_o))
         |-> $stable(sdo));
endmodule

bind sync_link_xcvr link_xcvr_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_master (mode_master),
   .clk_src_ext (clk_src_ext),
   .ext_tick    (ext_tick),
   .done        (done),
   .busy        (busy),
   .sclk_o      (sclk_o),
   .sdo         (sdo)
);

// File: tb/tb_sync_link_xcvr.sv
`timescale 1ns/1ps
module tb_sync_link_xcvr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_master = 1'b1, clk_src_ext = 1'b0, ext_tick = 1'b0;
   logic [1:0]  len_sel = 2'b00;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        done, busy, sclk_o, sdo;
   logic        sclk_i = 1'b0, sdi = 1'b0;

   int checks = 0, errors = 0, done_cnt = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sync_link_xcvr dut (
      .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .clk_src_ext(clk_src_ext),
      .ext_tick(ext_tick), .len_sel(len_sel), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .done(done), .busy(busy), .sclk_o(sclk_o), .sclk_i(sclk_i),
      .sdo(sdo), .sdi(sdi)
   );

   always @(negedge clk) if (done) done_cnt++;

   function automatic int nbits(input logic [1:0] c);
      return (c == 2'b00) ? 8 : (c == 2'b01) ? 16 : 32;
   endfunction

   function automatic logic [31:0] lmask(input int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic master_xfer(input logic [1:0] lc, input logic [31:0] tx, input logic [31:0] rx,
                              input bit ext, input bit poke);
      int n, cyc, k;
      bit ps, tk, got;
      n = nbits(lc);
      @(negedge clk);
      mode_master = 1'b1; clk_src_ext = ext; len_sel = lc;
      wr_data = tx; wr_en = 1'b1; ext_tick = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      cyc = 0; k = 0; ps = sclk_o; got = 0;
      chk("R2 busy after accept", {31'd0, busy}, 32'd1);
      chk("R3 first bit on sdo", {31'd0, sdo}, {31'd0, tx[n-1]});
      sdi = rx[n-1];
      while (!got && cyc < 600) begin
         tk = ext ? (cyc % 3 == 1) : 1'b0;
         ext_tick = tk;
         if (poke) begin
            wr_en   = (cyc == 3);
            wr_data = ~tx;
         end
         @(negedge clk);
         cyc++;
         if (ext && !tk) chk("R5 hold without tick", {31'd0, sclk_o}, {31'd0, ps});
         if (!ext && cyc < 2*n) begin
            chk("R2 busy per cycle", {31'd0, busy}, 32'd1);
            chk("R2 sclk_o per cycle", {31'd0, sclk_o}, {31'd0, cyc[0]});
         end
         if (!ps && sclk_o && k < n)
            chk(poke ? "R8 sdo bit after ignored write" : "R3 sdo bit at rise",
                {31'd0, sdo}, {31'd0, tx[n-1-k]});
         if (ps && !sclk_o) begin
            k++;
            if (k < n) sdi = rx[n-1-k];
         end
         ps = sclk_o;
         if (done) got = 1;
      end
      wr_en = 1'b0; ext_tick = 1'b0;
      chk("R7 done seen", {31'd0, got}, 32'd1);
      if (!ext) chk("R2 cycles to done", cyc, 2*n);
      chk("R2 falling edges per word", k, n);
      chk(poke ? "R8 rx word after ignored write" : "R4 rx word", rd_data, rx & lmask(n));
      chk("R7 busy low with done", {31'd0, busy}, 32'd0);
      chk("R9 clock idle low", {31'd0, sclk_o}, 32'd0);
      @(negedge clk);
      chk("R7 done single cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic slave_xfer(input logic [1:0] lc, input logic [31:0] tx, input logic [31:0] rx,
                             input bit poke);
      int n, d0;
      bit clk_seen;
      n = nbits(lc);
      clk_seen = 0;
      @(negedge clk);
      mode_master = 1'b0; len_sel = lc; sclk_i = 1'b0;
      wr_data = tx; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      d0 = done_cnt;
      for (int k = 0; k < n; k++) begin
         sdi = rx[n-1-k];
         repeat (6) begin
            @(negedge clk);
            if (sclk_o) clk_seen = 1;
         end
         chk(poke ? "R8 slave sdo after ignored write" : "R6 slave sdo bit",
             {31'd0, sdo}, {31'd0, tx[n-1-k]});
         sclk_i = 1'b1;
         for (int j = 0; j < 6; j++) begin
            wr_en   = poke && (k == 2) && (j == 2);
            wr_data = ~tx;
            @(negedge clk);
            if (sclk_o) clk_seen = 1;
         end
         wr_en = 1'b0;
         sclk_i = 1'b0;
      end
      repeat (8) @(negedge clk);
      chk("R6 sclk_o low in slave", {31'd0, clk_seen}, 32'd0);
      chk("R7 one done per slave word", done_cnt - d0, 1);
      chk(poke ? "R8 slave rx after ignored write" : "R6 slave rx word", rd_data, rx & lmask(n));
      chk("R7 slave busy low", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy reset", {31'd0, busy}, 32'd0);
      chk("R1 done reset", {31'd0, done}, 32'd0);
      chk("R1 sclk_o reset", {31'd0, sclk_o}, 32'd0);
      chk("R1 sdo reset", {31'd0, sdo}, 32'd0);
      chk("R1 rd_data reset", rd_data, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      master_xfer(2'b00, 32'h0000_00A5, 32'h0000_003C, 0, 0);
      master_xfer(2'b01, 32'h0000_BEEF, 32'h0000_1234, 0, 0);
      master_xfer(2'b10, 32'hDEAD_BEEF, 32'h0F0F_5A5A, 0, 0);
      master_xfer(2'b11, 32'h1234_5678, 32'h8765_4321, 0, 0);
      master_xfer(2'b00, 32'hFFFF_FF81, 32'hFFFF_FF7E, 0, 0);
      master_xfer(2'b01, 32'h0000_C3A1, 32'h0000_9E55, 1, 0);
      master_xfer(2'b00, 32'h0000_0096, 32'h0000_00E1, 0, 1);
      master_xfer(2'b10, 32'h8000_0001, 32'h7FFF_FFFE, 1, 1);

      slave_xfer(2'b00, 32'h0000_005A, 32'h0000_00C6, 0);
      slave_xfer(2'b01, 32'h0000_A55A, 32'h0000_3CC3, 0);
      slave_xfer(2'b10, 32'hCAFE_F00D, 32'h1357_9BDF, 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule